// File: doc/BRIEF.md
# Multi-Class Interrupt Distributor

This block tracks a small set of interrupt sources in three classes and offers each processing element (PE) its most urgent pending interrupt. Software-generated interrupts (SGIs) and private peripheral interrupts (PPIs) are banked: every PE has its own copy of their state and configuration. Shared peripheral interrupts (SPIs) have one global state and a configurable target mask.

Every source moves through four states: inactive, pending, active, and active-and-pending. Only an explicit deactivate strobe from a PE takes an active source out of the active states. Sources arrive as raw interrupt lines, as SGI requests written by a PE, and as acknowledge and deactivate strobes from the PEs. A single configuration write port sets the enable, priority, trigger mode and targets of one source per cycle.

For each PE the outputs are a request flag, the ID of the interrupt currently offered, and a registered acknowledge response that holds the ID the PE has claimed.

Top module: `irq_distrib`

## Requirements
- R1: After reset every source is inactive, disabled, edge-triggered, priority 0 and untargeted. `irq_req` is low and every `irq_id` and `ack_id` field reads 1023.
- R2: Each PE is offered the pending, enabled source that is eligible for it and has the lowest priority value. A tie goes to the lower ID. SGI n has ID n, PPI p has ID 16+p, and SPI k has ID 32+k, all in 10-bit fields. With nothing eligible, `irq_req` is low and `irq_id` is 1023.
- R3: A disabled source can still become pending, but it is never offered.
- R4: When `ack` is high while a source is offered, that source goes from pending to active. Its ID appears on `ack_id` one cycle later and it is no longer offered. `ack_id` keeps its value in cycles without `ack`.
- R5: When `ack` is high and no source is offered, `ack_id` becomes 1023 one cycle later.
- R6: A new edge on an active edge-triggered source makes it active-and-pending, and it is still not offered. A deactivate then leaves it pending.
- R7: A deactivate of an active source makes it inactive. A deactivate aimed at a pending or inactive source has no effect.
- R8: A level-triggered source is pending while its line is high and it is inactive or pending. It drops back to inactive if the line falls before the acknowledge. If the line is still high at deactivate, the source returns to pending.
- R9: An SPI is eligible for every PE whose bit is set in its target mask. If several PEs acknowledge the same SPI in one cycle, the lowest-numbered PE gets it and the others receive 1023. Any PE may deactivate an SPI.
- R10: PPI p of PE e is driven by `ppi_line[e*NPPI+p]` and is offered only to PE e.
- R11: An SGI write sets SGI `sgi_num` pending in every PE listed in `sgi_targets`, and each PE acknowledges it independently. SGIs are always edge-triggered, whatever level setting is written for them.
- R12: A configuration write updates one source in the next cycle. The source is chosen by `cfg_id`, together with `cfg_pe` for banked sources. A write changes the offered interrupt at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ppi_line | input | NPE*NPPI | Private peripheral lines, grouped by PE |
| spi_line | input | NSPI | Shared peripheral lines |
| sgi_wr | input | 1 | Software interrupt request strobe |
| sgi_num | input | ID_W | SGI number to raise |
| sgi_targets | input | NPE | PEs that receive the SGI |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pe | input | PE_W | Bank selected for SGI/PPI writes |
| cfg_id | input | ID_W | Interrupt ID to configure |
| cfg_enable | input | 1 | Enable forwarding |
| cfg_prio | input | PRIO_W | Priority, lower is more urgent |
| cfg_level | input | 1 | 1 = level-triggered, 0 = edge |
| cfg_targets | input | NPE | SPI target mask |
| ack | input | NPE | Acknowledge strobe per PE |
| deact | input | NPE | Deactivate strobe per PE |
| deact_id | input | NPE*ID_W | ID being deactivated, per PE |
| irq_req | output | NPE | Interrupt offered, per PE |
| irq_id | output | NPE*ID_W | Offered ID per PE, 1023 if none |
| ack_id | output | NPE*ID_W | Registered acknowledge response per PE |

## Verification
Every state change takes effect at the clock edge that samples the stimulus. Because `irq_req` and `irq_id` are combinational views of the state, they show the new choice one cycle after the stimulus, and `ack_id` is also due one cycle after `ack`. The bench drives inputs on the falling edge, removes them on the next falling edge, and compares results at that same falling edge, so each check falls on the first cycle in which its result is due. Sequences that span several steps, such as acknowledge, re-edge, deactivate and re-offer, are checked after every step rather than only at the end.

// File: rtl/irq_distrib.sv
module irq_distrib #(
  parameter int NPE      = 2,
  parameter int NSGI     = 4,
  parameter int NPPI     = 2,
  parameter int NSPI     = 4,
  parameter int PRIO_W   = 4,
  parameter int ID_W     = 10,
  parameter int PPI_BASE = 16,
  parameter int SPI_BASE = 32,
  localparam int PE_W    = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPE*NPPI-1:0]  ppi_line,
  input  logic [NSPI-1:0]      spi_line,
  input  logic                 sgi_wr,
  input  logic [ID_W-1:0]      sgi_num,
  input  logic [NPE-1:0]       sgi_targets,
  input  logic                 cfg_wr,
  input  logic [PE_W-1:0]      cfg_pe,
  input  logic [ID_W-1:0]      cfg_id,
  input  logic                 cfg_enable,
  input  logic [PRIO_W-1:0]    cfg_prio,
  input  logic                 cfg_level,
  input  logic [NPE-1:0]       cfg_targets,
  input  logic [NPE-1:0]       ack,
  input  logic [NPE-1:0]       deact,
  input  logic [NPE*ID_W-1:0]  deact_id,
  output logic [NPE-1:0]       irq_req,
  output logic [NPE*ID_W-1:0]  irq_id,
  output logic [NPE*ID_W-1:0]  ack_id
);

  localparam int NB = NSGI + NPPI;
  localparam logic [ID_W-1:0] SPUR = ID_W'(1023);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_PEND = 2'd1, ST_ACT = 2'd2, ST_BOTH = 2'd3;

  function automatic logic [ID_W-1:0] bank_id(input int b);
    return (b < NSGI) ? ID_W'(b) : ID_W'(PPI_BASE + b - NSGI);
  endfunction

  function automatic logic [1:0] step(input logic [1:0] s, input logic lvl, input logic line,
                                      input logic ev, input logic ah, input logic dh);
    logic [1:0] n;
    logic raise;
    raise = lvl ? line : ev;
    n = s;
    case (s)
      ST_IDLE: if (raise) n = ST_PEND;
      ST_PEND: if (ah) n = ST_ACT;
               else if (lvl && !line) n = ST_IDLE;
      ST_ACT:  if (dh) n = raise ? ST_PEND : ST_IDLE;
               else if (!lvl && ev) n = ST_BOTH;
      default: if (dh) n = ST_PEND;
    endcase
    return n;
  endfunction

  logic [NPE*NB*2-1:0]       b_st;
  logic [NPE*NB-1:0]         b_en;
  logic [NPE*NB*PRIO_W-1:0]  b_pr;
  logic [NPE*NB-1:0]         b_ack;
  logic [NSPI*2-1:0]         s_st;
  logic [NSPI-1:0]           s_en;
  logic [NSPI*PRIO_W-1:0]    s_pr;
  logic [NSPI*NPE-1:0]       s_tg;
  logic [NSPI-1:0]           s_ack;
  logic [NSPI-1:0]           s_dh;
  logic [NPE-1:0]            got;
  logic [NPE-1:0]            sel_v;
  logic [NPE*ID_W-1:0]       sel_id;

  always_comb begin
    logic v;
    logic is_spi;
    int idx;
    logic [PRIO_W-1:0] bp;
    logic [ID_W-1:0] bid;
    logic [NSPI-1:0] taken;
    taken = '0;
    b_ack = '0;
    s_ack = '0;
    got   = '0;
    sel_v = '0;
    sel_id = '0;
    for (int p = 0; p < NPE; p++) begin
      v = 1'b0; is_spi = 1'b0; idx = 0; bp = '1; bid = SPUR;
      for (int b = 0; b < NB; b++) begin
        if (b_en[p*NB+b] && b_st[(p*NB+b)*2 +: 2] == ST_PEND &&
            (!v || b_pr[(p*NB+b)*PRIO_W +: PRIO_W] < bp)) begin
          v = 1'b1; is_spi = 1'b0; idx = b;
          bp = b_pr[(p*NB+b)*PRIO_W +: PRIO_W];
          bid = bank_id(b);
        end
      end
      for (int k = 0; k < NSPI; k++) begin
        if (s_en[k] && s_tg[k*NPE+p] && s_st[k*2 +: 2] == ST_PEND &&
            (!v || s_pr[k*PRIO_W +: PRIO_W] < bp)) begin
          v = 1'b1; is_spi = 1'b1; idx = k;
          bp = s_pr[k*PRIO_W +: PRIO_W];
          bid = ID_W'(SPI_BASE + k);
        end
      end
      sel_v[p] = v;
      sel_id[p*ID_W +: ID_W] = bid;
      if (ack[p] && v) begin
        if (!is_spi) begin
          got[p] = 1'b1;
          b_ack[p*NB+idx] = 1'b1;
        end else if (!taken[idx]) begin
          got[p] = 1'b1;
          taken[idx] = 1'b1;
          s_ack[idx] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    s_dh = '0;
    for (int k = 0; k < NSPI; k++)
      for (int p = 0; p < NPE; p++)
        if (deact[p] && deact_id[p*ID_W +: ID_W] == ID_W'(SPI_BASE + k)) s_dh[k] = 1'b1;
  end

  assign irq_req = sel_v;
  assign irq_id  = sel_id;

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    for (genvar b = 0; b < NB; b++) begin : g_bank
      localparam logic [ID_W-1:0] MY_ID = bank_id(b);
      logic [1:0]        st;
      logic              en;
      logic              lvl;
      logic [PRIO_W-1:0] pr;
      logic              line, line_q, ev;
      logic              cfg_hit, dh;

      if (b < NSGI) begin : g_sgi
        assign line = 1'b0;
        assign ev   = sgi_wr && sgi_targets[p] && sgi_num == MY_ID;
      end else begin : g_ppi
        assign line = ppi_line[p*NPPI + b - NSGI];
        assign ev   = line && !line_q;
      end

      assign cfg_hit = cfg_wr && cfg_id == MY_ID && cfg_pe == PE_W'(p);
      assign dh      = deact[p] && deact_id[p*ID_W +: ID_W] == MY_ID;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st <= ST_IDLE; en <= 1'b0; lvl <= 1'b0; pr <= '0; line_q <= 1'b0;
        end else begin
          line_q <= line;
          st <= step(st, lvl, line, ev, b_ack[p*NB+b], dh);
          if (cfg_hit) begin
            en  <= cfg_enable;
            pr  <= cfg_prio;
            lvl <= (b < NSGI) ? 1'b0 : cfg_level;
          end
        end
      end

      assign b_st[(p*NB+b)*2 +: 2]           = st;
      assign b_en[p*NB+b]                    = en;
      assign b_pr[(p*NB+b)*PRIO_W +: PRIO_W] = pr;
    end

    logic [ID_W-1:0] rsp;
    always_ff @(posedge clk) begin
      if (!rst_n) rsp <= SPUR;
      else if (ack[p]) rsp <= got[p] ? sel_id[p*ID_W +: ID_W] : SPUR;
    end
    assign ack_id[p*ID_W +: ID_W] = rsp;
  end

  for (genvar k = 0; k < NSPI; k++) begin : g_spi
    logic [1:0]        st;
    logic              en, lvl, line_q, ev;
    logic [PRIO_W-1:0] pr;
    logic [NPE-1:0]    tg;

    assign ev = spi_line[k] && !line_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st <= ST_IDLE; en <= 1'b0; lvl <= 1'b0; pr <= '0; tg <= '0; line_q <= 1'b0;
      end else begin
        line_q <= spi_line[k];
        st <= step(st, lvl, spi_line[k], ev, s_ack[k], s_dh[k]);
        if (cfg_wr && cfg_id == ID_W'(SPI_BASE + k)) begin
          en <= cfg_enable; pr <= cfg_prio; lvl <= cfg_level; tg <= cfg_targets;
        end
      end
    end

    assign s_st[k*2 +: 2]           = st;
    assign s_en[k]                  = en;
    assign s_pr[k*PRIO_W +: PRIO_W] = pr;
    assign s_tg[k*NPE +: NPE]       = tg;
  end

endmodule

module irq_distrib_chk #(
  parameter int NPE      = 2,
  parameter int ID_W     = 10,
  parameter int SPI_BASE = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPE-1:0]      ack,
  input logic [NPE-1:0]      irq_req,
  input logic [NPE*ID_W-1:0] irq_id,
  input logic [NPE*ID_W-1:0] ack_id
);
  localparam logic [ID_W-1:0] SPUR = ID_W'(1023);

  for (genvar p = 0; p < NPE; p++) begin : g_chk
    assert_idle_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req[p] |-> irq_id[p*ID_W +: ID_W] == SPUR);
    assert_offer_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[p] |-> irq_id[p*ID_W +: ID_W] != SPUR);
    assert_rsp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ack[p] |=> $stable(ack_id[p*ID_W +: ID_W]));
    assert_rsp_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[p] && irq_req[p]) |=> (ack_id[p*ID_W +: ID_W] == $past(irq_id[p*ID_W +: ID_W]) ||
                                  ack_id[p*ID_W +: ID_W] == SPUR));
    assert_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[p] && !irq_req[p]) |=> ack_id[p*ID_W +: ID_W] == SPUR);
  end

  if (NPE >= 2) begin : g_pair
    assert_single_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[0] && ack[1]) |=> !(ack_id[0 +: ID_W] == ack_id[ID_W +: ID_W] &&
                               ack_id[0 +: ID_W] >= ID_W'(SPI_BASE) &&
                               ack_id[0 +: ID_W] != SPUR));
  end
endmodule

bind irq_distrib irq_distrib_chk #(.NPE(NPE), .ID_W(ID_W), .SPI_BASE(SPI_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .irq_req(irq_req), .irq_id(irq_id), .ack_id(ack_id)
);

// File: tb/test_irq_distrib.sv
`timescale 1ns/1ps
module test_irq_distrib;
  localparam int NPE = 2, NPPI = 2, NSPI = 4, ID_W = 10;
  localparam int SPUR = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPE*NPPI-1:0] ppi_line = '0;
  logic [NSPI-1:0] spi_line = '0;
  logic sgi_wr = 1'b0;
  logic [ID_W-1:0] sgi_num = '0;
  logic [NPE-1:0] sgi_targets = '0;
  logic cfg_wr = 1'b0;
  logic [0:0] cfg_pe = '0;
  logic [ID_W-1:0] cfg_id = '0;
  logic cfg_enable = 1'b0;
  logic [3:0] cfg_prio = '0;
  logic cfg_level = 1'b0;
  logic [NPE-1:0] cfg_targets = '0;
  logic [NPE-1:0] ack = '0;
  logic [NPE-1:0] deact = '0;
  logic [NPE*ID_W-1:0] deact_id = '0;
  logic [NPE-1:0] irq_req;
  logic [NPE*ID_W-1:0] irq_id;
  logic [NPE*ID_W-1:0] ack_id;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_distrib i_irq_distrib (.*);

  // entry: {prio SPI32, SPI33, SPI34, SPI35, expected id}
  localparam logic [25:0] PTAB [5] = '{
    {4'd5, 4'd3, 4'd7, 4'd9, 10'd33},
    {4'd2, 4'd2, 4'd8, 4'd8, 10'd32},
    {4'd9, 4'd9, 4'd1, 4'd1, 10'd34},
    {4'd15, 4'd15, 4'd15, 4'd0, 10'd35},
    {4'd4, 4'd4, 4'd4, 4'd4, 10'd32}
  };

  function automatic int oid(input int pe);
    return int'(irq_id[pe*ID_W +: ID_W]);
  endfunction
  function automatic int rid(input int pe);
    return int'(ack_id[pe*ID_W +: ID_W]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int pe, input int id, input bit en, input int prio, input bit lvl, input int tg);
    cfg_wr = 1; cfg_pe = 1'(pe); cfg_id = ID_W'(id); cfg_enable = en;
    cfg_prio = 4'(prio); cfg_level = lvl; cfg_targets = NPE'(tg);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse_spi(input int m);
    spi_line = NSPI'(m);
    @(negedge clk);
    spi_line = '0;
  endtask

  task automatic do_ack(input int m);
    ack = NPE'(m);
    @(negedge clk);
    ack = '0;
  endtask

  task automatic do_deact(input int pe, input int id);
    deact[pe] = 1'b1;
    deact_id[pe*ID_W +: ID_W] = ID_W'(id);
    @(negedge clk);
    deact = '0;
  endtask

  task automatic raise_sgi(input int num, input int tg);
    sgi_wr = 1; sgi_num = ID_W'(num); sgi_targets = NPE'(tg);
    @(negedge clk);
    sgi_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 irq_id pe0", oid(0), SPUR);
    chk("R1 irq_id pe1", oid(1), SPUR);
    chk("R1 ack_id pe0", rid(0), SPUR);

    // R2 R12: priority table over four SPIs pending at PE0
    for (int i = 0; i < 5; i++) begin
      for (int k = 0; k < 4; k++)
        cfg(0, 32 + k, 1, int'(PTAB[i][25 - 4*k -: 4]), 0, 1);
      if (i == 0) pulse_spi(4'b1111);
      chk("R2 R12 irq_req pe0", int'(irq_req[0]), 1);
      chk("R2 R12 irq_id pe0", oid(0), int'(PTAB[i][9:0]));
      chk("R9 untargeted pe1", int'(irq_req[1]), 0);
    end

    cfg(0, 32, 0, 4, 0, 1);
    chk("R3 disabled skipped", oid(0), 33);
    cfg(0, 32, 1, 4, 0, 1);
    chk("R3 re-enabled", oid(0), 32);

    do_deact(0, 32);
    chk("R7 deact on pending ignored", oid(0), 32);

    do_ack(1);
    chk("R4 ack_id", rid(0), 32);
    chk("R4 next offered", oid(0), 33);
    pulse_spi(4'b0001);
    chk("R6 active-and-pending not offered", oid(0), 33);
    do_deact(0, 32);
    chk("R6 back to pending", oid(0), 32);

    for (int i = 0; i < 4; i++) begin
      do_ack(1);
      chk("R4 ack order", rid(0), 32 + i);
      do_deact(0, 32 + i);
    end
    chk("R7 all inactive", int'(irq_req[0]), 0);
    @(negedge clk);
    chk("R4 ack_id held", rid(0), 35);

    do_ack(1);
    chk("R5 spurious", rid(0), SPUR);

    // R8 level SPI34 targeted at PE1
    cfg(0, 34, 1, 2, 1, 2);
    spi_line[2] = 1'b1;
    @(negedge clk);
    chk("R8 level pending", int'(irq_req[1]), 1);
    chk("R8 level id", oid(1), 34);
    spi_line[2] = 1'b0;
    @(negedge clk);
    chk("R8 line drop clears", int'(irq_req[1]), 0);
    spi_line[2] = 1'b1;
    @(negedge clk);
    do_ack(2);
    chk("R8 ack level", rid(1), 34);
    chk("R8 active not offered", int'(irq_req[1]), 0);
    do_deact(1, 34);
    chk("R8 still high returns pending", oid(1), 34);
    do_ack(2);
    spi_line[2] = 1'b0;
    do_deact(1, 34);
    chk("R8 low at deact inactive", int'(irq_req[1]), 0);

    // R9 1-of-N
    cfg(0, 33, 1, 1, 0, 3);
    pulse_spi(4'b0010);
    chk("R9 offered pe0", oid(0), 33);
    chk("R9 offered pe1", oid(1), 33);
    do_ack(3);
    chk("R9 winner pe0", rid(0), 33);
    chk("R9 loser pe1", rid(1), SPUR);
    chk("R9 no longer offered", int'(irq_req), 0);
    do_deact(1, 33);
    pulse_spi(4'b0010);
    chk("R9 deact by other pe", int'(irq_req), 3);
    do_ack(1);
    do_deact(0, 33);

    // R10 PPI 17 of PE1
    cfg(1, 17, 1, 3, 0, 0);
    ppi_line = 4'b1000;
    @(negedge clk);
    ppi_line = '0;
    chk("R10 only own pe", int'(irq_req), 2);
    chk("R10 ppi id", oid(1), 17);
    do_ack(2);
    chk("R10 ack", rid(1), 17);
    do_deact(1, 17);

    // R11 SGI to both PEs
    cfg(0, 2, 1, 5, 0, 0);
    cfg(1, 2, 1, 5, 0, 0);
    raise_sgi(2, 3);
    chk("R11 pe0 sgi", oid(0), 2);
    chk("R11 pe1 sgi", oid(1), 2);
    do_ack(1);
    chk("R11 pe0 ack", rid(0), 2);
    chk("R11 pe1 independent", oid(1), 2);
    do_ack(2);
    chk("R11 pe1 ack", rid(1), 2);
    do_deact(0, 2);
    do_deact(1, 2);
    chk("R11 cleared", int'(irq_req), 0);

    cfg(0, 1, 1, 6, 1, 0);
    raise_sgi(1, 1);
    @(negedge clk);
    chk("R11 sgi ignores level setting", oid(0), 1);
    do_ack(1);
    do_deact(0, 1);
    chk("R11 sgi done", int'(irq_req), 0);

    finish_run();
  end
endmodule